// File: doc/BRIEF.md
# Packed Signed 16-bit Multiply Unit

This block multiplies two 64-bit operands as four independent signed 16-bit lanes. It returns one of three result forms from the same set of lane products. The low form keeps the lower 16 bits of each 32-bit product. The high form keeps the upper 16 bits. The pair-sum form adds neighbouring products into two 32-bit results. The caller presents a valid strobe, a 2-bit operation code and the two operands. The result appears with its own valid flag two cycles later.

The pipeline has two register stages. The first stage registers the four full-width lane products together with the operation code and a valid bit. The second stage forms the chosen result and registers it. A new operation may enter on every cycle, and operations of different kinds may follow each other freely. Each result leaves in issue order with the form that was selected for it. Saturation and unsigned forms are not part of this block.

Top module: `pmul_unit`

## Requirements
- R1: With `in_op` = 0 (low form), result lane k (bits 16k+15:16k) equals bits 15:0 of the signed product of operand lanes `in_a` k and `in_b` k.
- R2: With `in_op` = 1 (high form), result lane k equals bits 31:16 of the signed 32-bit product of operand lanes k.
- R3: With `in_op` = 2 (pair-sum form), result bits 31:0 equal the sum of the signed products of lanes 0 and 1, and result bits 63:32 equal the sum of the signed products of lanes 2 and 3.
- R4: The pair-sum wraps modulo 2^32. When all four lanes of both operands are 0x8000, each 32-bit half of the result is 0x80000000.
- R5: `out_valid` is high in exactly the cycle two clock edges after a cycle with `in_valid` high, and low two edges after a cycle with `in_valid` low. One operation is accepted on every cycle.
- R6: The operation code travels with its operands. Back-to-back operations with different codes each produce their own form, in issue order.
- R7: A synchronous active-high `rst` clears every pipeline valid bit and the result register. An operation in flight when reset is taken never appears at the output.
- R8: `in_op` = 3 is reserved and produces an all-zero result with `out_valid` set.
- R9: While `out_valid` is low, `out_result` holds the last result, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 2 | 0 low, 1 high, 2 pair-sum, 3 reserved |
| in_a | input | 64 | First operand, four signed 16-bit lanes |
| in_b | input | 64 | Second operand, four signed 16-bit lanes |
| out_valid | output | 1 | Result valid |
| out_result | output | 64 | Result |

## Verification
The bench builds the unit with its default parameters: 16-bit lanes and four lanes. With these values the extreme words 0x8000, 0x7FFF, 0xFFFF and 0 land exactly on the sign boundaries of each product. There are also exactly two pair sums, so the wrap at 2^32 and the placement of both 32-bit halves can be checked directly. The single-lane width also keeps a lane-by-lane reference product inside a 32-bit integer.

// File: rtl/pmul_pkg.sv
package pmul_pkg;
    typedef enum logic [1:0] {
        OP_LOW  = 2'd0,
        OP_HIGH = 2'd1,
        OP_PAIR = 2'd2,
        OP_RSVD = 2'd3
    } pmul_op_e;
endpackage

// File: rtl/pmul_prod_stage.sv
module pmul_prod_stage
    import pmul_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int LANES  = 4
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  in_valid,
    input  pmul_op_e                              in_op,
    input  logic [LANES*LANE_W-1:0]               in_a,
    input  logic [LANES*LANE_W-1:0]               in_b,
    output logic                                  s1_valid,
    output pmul_op_e                              s1_op,
    output logic [LANES-1:0][2*LANE_W-1:0]        s1_prod
);
    localparam int PROD_W = 2 * LANE_W;

    typedef struct packed {
        logic                            valid;
        pmul_op_e                        op;
        logic [LANES-1:0][PROD_W-1:0]    prod;
    } stage_t;

    stage_t st_d, st_q;
    logic [LANES-1:0][PROD_W-1:0] lane_prod;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] op_a, op_b;
        logic signed [PROD_W-1:0] ext_a, ext_b;
        assign op_a  = in_a[l*LANE_W +: LANE_W];
        assign op_b  = in_b[l*LANE_W +: LANE_W];
        assign ext_a = $signed({{LANE_W{op_a[LANE_W-1]}}, op_a});
        assign ext_b = $signed({{LANE_W{op_b[LANE_W-1]}}, op_b});
        assign lane_prod[l] = ext_a * ext_b;
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.op   = in_op;
            st_d.prod = lane_prod;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign s1_valid = st_q.valid;
    assign s1_op    = st_q.op;
    assign s1_prod  = st_q.prod;

    // R5
    stage_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> s1_valid);
endmodule

// File: rtl/pmul_form_stage.sv
module pmul_form_stage
    import pmul_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int LANES  = 4
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  s1_valid,
    input  pmul_op_e                              s1_op,
    input  logic [LANES-1:0][2*LANE_W-1:0]        s1_prod,
    output logic                                  out_valid,
    output logic [LANES*LANE_W-1:0]               out_result
);
    localparam int PROD_W = 2 * LANE_W;
    localparam int PAIRS  = LANES / 2;
    localparam int RES_W  = LANES * LANE_W;

    typedef struct packed {
        logic             valid;
        logic [RES_W-1:0] result;
    } form_t;

    form_t fm_d, fm_q;
    logic [RES_W-1:0] low_form, high_form, pair_form;

    always_comb begin
        low_form  = '0;
        high_form = '0;
        pair_form = '0;
        for (int l = 0; l < LANES; l++) begin
            low_form[l*LANE_W +: LANE_W]  = s1_prod[l][LANE_W-1:0];
            high_form[l*LANE_W +: LANE_W] = s1_prod[l][PROD_W-1:LANE_W];
        end
        for (int p = 0; p < PAIRS; p++) begin
            pair_form[p*PROD_W +: PROD_W] = s1_prod[2*p] + s1_prod[2*p+1];
        end
    end

    always_comb begin
        fm_d       = fm_q;
        fm_d.valid = s1_valid;
        if (s1_valid) begin
            unique case (s1_op)
                OP_LOW:  fm_d.result = low_form;
                OP_HIGH: fm_d.result = high_form;
                OP_PAIR: fm_d.result = pair_form;
                default: fm_d.result = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fm_q <= '0;
        end else begin
            fm_q <= fm_d;
        end
    end

    assign out_valid  = fm_q.valid;
    assign out_result = fm_q.result;

    // R9
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !s1_valid |=> $stable(out_result));
endmodule

// File: rtl/pmul_unit.sv
module pmul_unit
    import pmul_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int LANES  = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [1:0]                in_op,
    input  logic [LANES*LANE_W-1:0]   in_a,
    input  logic [LANES*LANE_W-1:0]   in_b,
    output logic                      out_valid,
    output logic [LANES*LANE_W-1:0]   out_result
);
    localparam int PROD_W = 2 * LANE_W;
    localparam int RES_W  = LANES * LANE_W;

    logic                         s1_valid;
    pmul_op_e                     s1_op;
    logic [LANES-1:0][PROD_W-1:0] s1_prod;
    pmul_op_e                     op_sel;

    assign op_sel = pmul_op_e'(in_op);

    pmul_prod_stage #(.LANE_W(LANE_W), .LANES(LANES)) u_prod (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_op    (op_sel),
        .in_a     (in_a),
        .in_b     (in_b),
        .s1_valid (s1_valid),
        .s1_op    (s1_op),
        .s1_prod  (s1_prod)
    );

    pmul_form_stage #(.LANE_W(LANE_W), .LANES(LANES)) u_form (
        .clk        (clk),
        .rst        (rst),
        .s1_valid   (s1_valid),
        .s1_op      (s1_op),
        .s1_prod    (s1_prod),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    // R5
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##1 out_valid);

    // R5
    idle_latency_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ##1 !out_valid);

    // R8
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'd3) |=> ##1 (out_result == '0));

    // R1
    unit_low_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'd0 && in_b == {LANES{LANE_W'(1)}})
        |=> ##1 (out_result == $past(in_a, 2)));

    initial begin
        // R3
        even_lanes_chk: assert (LANES % 2 == 0 && LANES > 0);
    end
endmodule

// File: tb/pmul_unit_bench.sv
module pmul_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  in_op;
    logic [63:0] in_a, in_b;
    logic        out_valid;
    logic [63:0] out_result;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pmul_unit u_pmul_unit (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_op      (in_op),
        .in_a       (in_a),
        .in_b       (in_b),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    function automatic logic [63:0] model(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b);
        int p [4];
        logic [63:0] r = '0;
        for (int l = 0; l < 4; l++) begin
            p[l] = int'($signed(a[16*l +: 16])) * int'($signed(b[16*l +: 16]));
        end
        case (op)
            2'd0: for (int l = 0; l < 4; l++) r[16*l +: 16] = p[l][15:0];
            2'd1: for (int l = 0; l < 4; l++) r[16*l +: 16] = p[l][31:16];
            2'd2: begin
                r[31:0]  = 32'(p[0] + p[1]);
                r[63:32] = 32'(p[2] + p[3]);
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_one(input string req, input logic [1:0] op, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check({req, " valid"}, 64'(out_valid), 64'd1);
        check(req, out_result, model(op, a, b));
    endtask

    function automatic logic [15:0] corner(input int k);
        case (k % 5)
            0: return 16'h8000;
            1: return 16'h7FFF;
            2: return 16'hFFFF;
            3: return 16'h0000;
            default: return 16'($urandom);
        endcase
    endfunction

    function automatic logic [63:0] mixed(input int seed);
        logic [63:0] v;
        for (int l = 0; l < 4; l++) v[16*l +: 16] = corner(seed + 3*l);
        return v;
    endfunction

    task automatic t_reset;
        rst = 1'b1; in_valid = 1'b0; in_op = 2'd0; in_a = '0; in_b = '0;
        repeat (3) @(negedge clk);
        check("R7 reset valid", 64'(out_valid), 64'd0);
        check("R7 reset result", out_result, 64'd0);
        rst = 1'b0;
    endtask

    task automatic t_low;
        run_one("R1 corners", 2'd0, 64'h8000_7FFF_FFFF_0000, 64'h8000_8000_7FFF_FFFF);
        run_one("R1 unit b", 2'd0, 64'h1234_8000_FFFF_7FFF, 64'h0001_0001_0001_0001);
        for (int i = 0; i < 6; i++)
            run_one("R1 mixed", 2'd0, mixed(i), mixed(i + 7));
    endtask

    task automatic t_high;
        run_one("R2 corners", 2'd1, 64'h8000_7FFF_FFFF_8000, 64'h8000_7FFF_FFFF_7FFF);
        run_one("R2 neg one", 2'd1, 64'hFFFF_0002_8000_0000, 64'h0001_FFFF_0001_1234);
        for (int i = 0; i < 6; i++)
            run_one("R2 mixed", 2'd1, mixed(i + 2), mixed(i + 11));
    endtask

    task automatic t_pair;
        run_one("R3 small", 2'd2, 64'h0004_0003_0002_0001, 64'h0008_0007_0006_0005);
        check("R3 low dword", out_result[31:0], 32'd17);
        check("R3 high dword", out_result[63:32], 32'd53);
        run_one("R3 signs", 2'd2, 64'hFFFF_7FFF_8000_0001, 64'h7FFF_FFFF_0001_8000);
        for (int i = 0; i < 6; i++)
            run_one("R3 mixed", 2'd2, mixed(i + 4), mixed(i + 1));
    endtask

    task automatic t_wrap;
        run_one("R4 wrap", 2'd2, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000);
        check("R4 wrap value", out_result, 64'h8000_0000_8000_0000);
    endtask

    task automatic t_latency;
        @(negedge clk);
        in_valid = 1'b1; in_op = 2'd1; in_a = 64'h7FFF_7FFF_7FFF_7FFF; in_b = in_a;
        @(negedge clk);
        in_valid = 1'b0;
        check("R5 one edge", 64'(out_valid), 64'd0);
        @(negedge clk);
        check("R5 two edges", 64'(out_valid), 64'd1);
        @(negedge clk);
        check("R5 three edges", 64'(out_valid), 64'd0);
    endtask

    task automatic t_stream;
        logic [1:0]  ops [8];
        logic [63:0] as [8];
        logic [63:0] bs [8];
        for (int i = 0; i < 8; i++) begin
            ops[i] = 2'(i % 4); as[i] = mixed(i * 5); bs[i] = mixed(i * 3 + 1);
        end
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                check("R6 stream valid", 64'(out_valid), 64'd1);
                check("R6 stream order", out_result, model(ops[i-2], as[i-2], bs[i-2]));
            end
            in_valid = (i < 8);
            if (i < 8) begin
                in_op = ops[i]; in_a = as[i]; in_b = bs[i];
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reserved;
        run_one("R8 reserved", 2'd3, 64'h7FFF_8000_1234_FFFF, 64'h7FFF_8000_5678_FFFF);
        check("R8 zero", out_result, 64'd0);
    endtask

    task automatic t_hold;
        logic [63:0] kept;
        run_one("R9 setup", 2'd0, 64'h0003_0005_0007_0009, 64'h0002_0002_0002_0002);
        kept = out_result;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_op = 2'(i); in_a = {$urandom, $urandom}; in_b = {$urandom, $urandom};
        end
        @(negedge clk);
        check("R9 idle valid", 64'(out_valid), 64'd0);
        check("R9 idle hold", out_result, kept);
    endtask

    task automatic t_flush;
        @(negedge clk);
        in_valid = 1'b1; in_op = 2'd0; in_a = 64'h1111_2222_3333_4444; in_b = 64'h0003_0003_0003_0003;
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R7 flush valid", 64'(out_valid), 64'd0);
        check("R7 flush result", out_result, 64'd0);
        @(negedge clk);
        check("R7 no late valid", 64'(out_valid), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_low();
        t_high();
        t_pair();
        t_wrap();
        t_latency();
        t_stream();
        t_reserved();
        t_hold();
        t_flush();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule